// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block turns four asynchronous external interrupt lines into latched request flags and a single request line to a processor core. Each line is first brought into the clock domain by a short synchronizer chain, then compared with its value one cycle earlier to find transitions. The lower group of lines always reacts to high-to-low transitions. Each line in the upper group has a 2-bit mode field that selects one of four behaviours: ignore the line, react to falling transitions, react to rising transitions, or react to both.

A global enable gates the request output. Hardware clears the enable when the core acknowledges an interrupt, and a return-from-interrupt strobe sets it again. Software can also write the enable. A per-source mask picks which latched flags may raise the request. Flags keep latching while the enable is off, so no transition is lost during a handler. Software reads and writes the enable, flags, mask and mode fields through a small register port. Reads are combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the enable, every flag, the mask, and every mode field are 0, and `irq_req` is 0.
- R2: Flags 0 and 1 are set by a high-to-low transition of `ext_pin[0]` and `ext_pin[1]`. A low-to-high transition leaves them unchanged.
- R3: Register address 3 holds the mode fields for the upper lines. Bits 1:0 control `ext_pin[2]` and bits 3:2 control `ext_pin[3]`. The encodings are 00 = ignore, 01 = falling, 10 = rising, 11 = both. A transition that the field does not select leaves the flag unchanged.
- R4: When a pin level is driven after a clock edge and held, the matching flag reads 0 after the second following rising clock edge and reads 1 after the third.
- R5: A flag stays at 1 until software writes 0 to its bit at address 1. Writing 1 to a bit leaves that flag unchanged. If a selected transition lands in the same cycle as a clearing write, the flag stays at 1.
- R6: `irq_req` is 1 exactly when the enable is 1 and some flag whose mask bit (address 2, bit i for line i) is 1 is also 1. Flags still latch while the enable is 0.
- R7: A cycle with `irq_ack` high clears the enable at the next edge. This takes priority over `irq_ret` and over a software write in the same cycle.
- R8: A cycle with `irq_ret` high and `irq_ack` low sets the enable at the next edge. Without either strobe, a write to address 0 loads bit 0 into the enable.
- R9: Reads return the enable in bit 0 of address 0, the flags at address 1 and the mask at address 2, with all unused bits 0. A read of address 3 always returns 0.
- R10: The synchronizer stages reset to the high level. A line held high through reset and after it sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | NUM_PINS | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq_ack | input | 1 | Core accepted the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench uses the default parameters: four lines, two of them fixed to falling transitions, and a two-stage synchronizer. This makes 4-bit register data, so every mode field and every flag can be reached at the register port. With two programmable lines, each test pattern can put the two fields in different modes at once, so cross-coupling between the fields would show up. Because the pipeline is two stages deep, the set cycle is fixed and countable. That lets the bench make the clearing write collide exactly with a transition, and check the flag one cycle before and one cycle after it sets.

// File: rtl/ext_irq_pkg.sv
// Shared definitions for the external interrupt controller: the
// per-line detection mode and the register addresses.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_FLAG = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MASK = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_MODE = 2'd3;

endpackage

// File: rtl/ext_irq_sync.sv
// Synchronizer for one asynchronous line.
// Brings the line through STAGES flops and also gives the synchronized
// value delayed by one cycle, so the caller can find transitions.
// Assumes: STAGES >= 2. Every flop resets to RESET_VAL, so a line that
// idles at RESET_VAL shows no false transition after reset.
module ext_irq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_now,
    output logic pin_prev
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
        end
    end

    // Keep the last synchronized value for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign pin_now  = chain_q[STAGES-1];
    assign pin_prev = prev_q;

endmodule

// File: rtl/ext_irq_edge_det.sv
// Transition classifier for one line.
// Gives a one-cycle hit when the current and previous synchronized levels
// differ in the direction that the mode selects.
// Assumes: both inputs are already in the clock domain.
module ext_irq_edge_det
    import ext_irq_pkg::*;
(
    input  edge_mode_e mode,
    input  logic       level_now,
    input  logic       level_prev,
    output logic       hit
);

    logic fell;
    logic rose;

    // Classify the transition seen this cycle.
    always_comb begin
        fell = level_prev & ~level_now;
        rose = ~level_prev & level_now;
    end

    // Keep only the transitions that the mode selects.
    always_comb begin
        unique case (mode)
            EDGE_NONE: hit = 1'b0;
            EDGE_FALL: hit = fell;
            EDGE_RISE: hit = rose;
            EDGE_BOTH: hit = fell | rose;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ext_irq_regs.sv
// Register state of the interrupt controller: the global enable, the
// sticky request flags, the per-source mask and the write-only mode
// fields, with a combinational read mux.
// Assumes: DATA_W >= NUM_PINS and DATA_W >= MODE_W. The hit inputs are
// one-cycle pulses.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int MODE_W   = 4,
    parameter int DATA_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                irq_ack,
    input  logic                irq_ret,
    output logic                gie,
    output logic [NUM_PINS-1:0] flags,
    output logic [NUM_PINS-1:0] mask,
    output logic [MODE_W-1:0]   mode_cfg
);

    logic                gie_q;
    logic [NUM_PINS-1:0] flag_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [MODE_W-1:0]   mode_q;
    logic [NUM_PINS-1:0] clr_vec;
    logic                wr_ctrl;
    logic                wr_flag;
    logic                wr_mask;
    logic                wr_mode;

    // Decode which register a write targets.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_flag = wr_en && (wr_addr == ADDR_FLAG);
        wr_mask = wr_en && (wr_addr == ADDR_MASK);
        wr_mode = wr_en && (wr_addr == ADDR_MODE);
    end

    // A written 0 clears the matching flag; a written 1 keeps it.
    always_comb begin
        clr_vec = wr_flag ? ~wr_data[NUM_PINS-1:0] : '0;
    end

    // Global enable: acknowledge clears, return sets, software writes last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (irq_ack) begin
            gie_q <= 1'b0;
        end else if (irq_ret) begin
            gie_q <= 1'b1;
        end else if (wr_ctrl) begin
            gie_q <= wr_data[0];
        end
    end

    // Sticky flags: a new hit wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | hit;
        end
    end

    // Per-source mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= wr_data[NUM_PINS-1:0];
        end
    end

    // Mode fields of the programmable lines; reset means ignore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= wr_data[MODE_W-1:0];
        end
    end

    // Read mux; the mode register cannot be read back.
    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = DATA_W'(gie_q);
            ADDR_FLAG: rd_data = DATA_W'(flag_q);
            ADDR_MASK: rd_data = DATA_W'(mask_q);
            default:   rd_data = '0;
        endcase
    end

    assign gie      = gie_q;
    assign flags    = flag_q;
    assign mask     = mask_q;
    assign mode_cfg = mode_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
// Edge-selectable external interrupt controller (top).
// Synchronizes each line, classifies transitions (the first NUM_FIXED
// lines are fixed to falling, the rest take a 2-bit mode field), latches
// sticky flags and raises irq_req while the global enable allows it.
// Assumes: 0 <= NUM_FIXED < NUM_PINS and SYNC_STAGES >= 2.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int   NUM_PINS    = 4,
    parameter int   NUM_FIXED   = 2,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1,
    localparam int  PROG_PINS   = NUM_PINS - NUM_FIXED,
    localparam int  MODE_W      = 2 * PROG_PINS,
    localparam int  DATA_W      = (NUM_PINS > MODE_W) ? NUM_PINS : MODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                irq_ack,
    input  logic                irq_ret,
    output logic                irq_req
);

    logic [NUM_PINS-1:0] lvl_now;
    logic [NUM_PINS-1:0] lvl_prev;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] flags;
    logic [NUM_PINS-1:0] mask;
    logic [MODE_W-1:0]   mode_cfg;
    logic                gie;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
        edge_mode_e line_mode;

        ext_irq_sync #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (IDLE_LEVEL)
        ) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (ext_pin[i]),
            .pin_now   (lvl_now[i]),
            .pin_prev  (lvl_prev[i])
        );

        if (i < NUM_FIXED) begin : g_fixed
            // Fixed lines always react to falling transitions.
            assign line_mode = EDGE_FALL;
        end else begin : g_prog
            // Programmable lines take their field from the mode register.
            assign line_mode = edge_mode_e'(mode_cfg[2*(i-NUM_FIXED) +: 2]);
        end

        ext_irq_edge_det u_det (
            .mode       (line_mode),
            .level_now  (lvl_now[i]),
            .level_prev (lvl_prev[i]),
            .hit        (hit[i])
        );
    end

    ext_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .MODE_W   (MODE_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_ack  (irq_ack),
        .irq_ret  (irq_ret),
        .gie      (gie),
        .flags    (flags),
        .mask     (mask),
        .mode_cfg (mode_cfg)
    );

    // Raise the request for any unmasked pending flag while enabled.
    always_comb begin
        irq_req = gie && (|(flags & mask));
    end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Property checker for ext_irq_ctrl, bound to every instance of it.
// Watches the enable, flag and request behaviour at the register state.
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_ack,
    input logic                irq_ret,
    input logic                irq_req,
    input logic                gie,
    input logic [NUM_PINS-1:0] flags,
    input logic                wr_en,
    input logic [REG_AW-1:0]   wr_addr,
    input logic [REG_AW-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0) && !gie && !irq_req); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_FLAG)) |=> ((flags & $past(flags)) == $past(flags))); // R5

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req); // R6

    AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie); // R7

    AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> gie); // R8

    AST_MODE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_MODE) |-> (rd_data == '0)); // R9

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_ack (irq_ack),
    .irq_ret (irq_ret),
    .irq_req (irq_req),
    .gie     (gie),
    .flags   (flags),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/ext_irq_ctrl_bench.sv
// Self-checking bench for ext_irq_ctrl: directed corner cases plus
// seeded random mode/transition/mask patterns.
module ext_irq_ctrl_bench;

    localparam int NP = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] ext_pin = '1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_ack = 1'b0;
    logic          irq_ret = 1'b0;
    logic          irq_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_pin (ext_pin),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_ack (irq_ack),
        .irq_ret (irq_ret),
        .irq_req (irq_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Expected hit for a line given its mode and the old/new levels.
    function automatic bit exp_hit(input int line, input logic [3:0] modes,
                                   input bit old_l, input bit new_l);
        logic [1:0] m;
        bit fell, rose;
        fell = old_l && !new_l;
        rose = !old_l && new_l;
        if (line < 2) return fell;
        m = modes[2*(line-2) +: 2];
        case (m)
            2'b01:   return fell;
            2'b10:   return rose;
            2'b11:   return fell || rose;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit exp_req(input bit g, input logic [3:0] f, input logic [3:0] m);
        return g && ((f & m) != 0);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd1234));
        ext_pin = '1;
        idle(4);
        rst_n = 1'b1;

        // R1: reset state
        reg_rd(2'd0, v); chk("R1 ctrl", v, 0);
        reg_rd(2'd1, v); chk("R1 flags", v, 0);
        reg_rd(2'd2, v); chk("R1 mask", v, 0);
        chk("R1 irq_req", int'(irq_req), 0);

        // R10: lines high through reset set nothing
        idle(6);
        reg_rd(2'd1, v); chk("R10 no false flag", v, 0);

        // R3: reset modes ignore lines 2/3
        @(negedge clk); ext_pin[2] = 1'b0; ext_pin[3] = 1'b0;
        idle(6);
        reg_rd(2'd1, v); chk("R3 reset mode ignores", v, 0);
        @(negedge clk); ext_pin[2] = 1'b1; ext_pin[3] = 1'b1;
        idle(6);

        // R9: mode register reads 0
        reg_wr(2'd3, 4'hF);
        reg_rd(2'd3, v); chk("R9 mode reads zero", v, 0);
        reg_wr(2'd3, 4'h0);

        // R2: rising on line 0 ignored, falling sets
        @(negedge clk); ext_pin[0] = 1'b0;
        idle(6); reg_wr(2'd1, 4'h0);
        @(negedge clk); ext_pin[0] = 1'b1;
        idle(6);
        reg_rd(2'd1, v); chk("R2 rising ignored", v, 0);
        @(negedge clk); ext_pin[0] = 1'b0;
        idle(6);
        reg_rd(2'd1, v); chk("R2 falling sets", v, 1);

        // R5: writing 1 keeps, writing 0 clears
        reg_wr(2'd1, 4'hF);
        reg_rd(2'd1, v); chk("R5 write one keeps", v, 1);
        reg_wr(2'd1, 4'hE);
        reg_rd(2'd1, v); chk("R5 write zero clears", v, 0);

        // R4: latency of line 1 falling transition
        @(negedge clk); ext_pin[1] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rd_addr = 2'd1; #1;
        chk("R4 not yet after two edges", int'(rd_data), 0);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R4 set after three edges", int'(rd_data), 2);
        reg_wr(2'd1, 4'h0);
        @(negedge clk); ext_pin[0] = 1'b1; ext_pin[1] = 1'b1;
        idle(6);

        // R5: transition colliding with clearing write
        @(negedge clk); ext_pin[0] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 4'h0;
        @(negedge clk); wr_en = 1'b0;
        reg_rd(2'd1, v); chk("R5 hit wins over clear", v, 1);

        // R6: flags latch with enable off, request follows enable and mask
        reg_wr(2'd2, 4'h1);
        @(negedge clk); chk("R6 no req while disabled", int'(irq_req), 0);
        reg_wr(2'd0, 4'h1);
        @(negedge clk); chk("R6 req when enabled", int'(irq_req), 1);
        reg_wr(2'd2, 4'h2);
        @(negedge clk); chk("R6 masked off", int'(irq_req), 0);
        reg_wr(2'd2, 4'h1);

        // R7: acknowledge clears enable
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        reg_rd(2'd0, v); chk("R7 ack clears", v, 0);
        chk("R7 req drops", int'(irq_req), 0);

        // R8: return sets enable
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
        reg_rd(2'd0, v); chk("R8 ret sets", v, 1);

        // R7: ack wins over ret and write
        @(negedge clk); irq_ack = 1'b1; irq_ret = 1'b1;
        @(negedge clk); irq_ack = 1'b0; irq_ret = 1'b0;
        reg_rd(2'd0, v); chk("R7 ack over ret", v, 0);
        reg_wr(2'd0, 4'h1);
        reg_rd(2'd0, v); chk("R8 software write", v, 1);
        reg_wr(2'd0, 4'h0);
        reg_wr(2'd1, 4'h0);
        @(negedge clk); ext_pin = '1;
        idle(6);
        reg_wr(2'd1, 4'h0);

        // R3 and R6: random modes, transitions, masks
        for (int it = 0; it < 80; it++) begin
            logic [3:0] modes, fexp, m;
            int line;
            bit oldl, g;
            modes = 4'($urandom);
            reg_wr(2'd3, modes);
            reg_wr(2'd1, 4'h0);
            line = int'($urandom_range(0, 3));
            oldl = ext_pin[line];
            @(negedge clk); ext_pin[line] = ~oldl;
            idle(6);
            fexp = '0;
            fexp[line] = exp_hit(line, modes, oldl, ~oldl);
            reg_rd(2'd1, v);
            chk((line < 2) ? "R2 random" : "R3 random", v, int'(fexp));
            m = 4'($urandom);
            g = 1'($urandom);
            reg_wr(2'd2, m);
            reg_wr(2'd0, {3'b000, g});
            @(negedge clk);
            chk("R6 random req", int'(irq_req), int'(exp_req(g, fexp, m)));
            reg_wr(2'd0, 4'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule